// File: doc/BRIEF.md
# Cascadable Bit-Serial Configuration Memory

This block is the readout side of a serial configuration memory that feeds a configurable device at power-up. It holds `CAP_BITS` bits and sends them one per clock on a single output line. A word address counter and a bit-within-word counter pick the bit. The receiving device supplies the clock, pulls the active-low chip enable, and uses the combined reset/output-enable line to restart the stream before each load.

When a memory has sent its last bit, it drives its cascade output low. That output is wired to the chip enable of the next memory, so a chain of memories reads out as one longer stream with no gap between them. The stored contents come from an arithmetic pattern that is fixed by parameters. The output is modelled as a data value plus a separate drive-enable flag, not as a tri-state pin.

Top module: `cfg_serial_rom`

## Requirements
- R1: Stream bit `i` is taken from word `a = i / WORD_W`, whose value is `(a*MULT + SEED) mod 2^WORD_W`. With `MSB_FIRST=1` the word's bits go out from the highest position down; with `MSB_FIRST=0` they go out from bit 0 up.
- R2: The counters advance by exactly one bit on a rising clock edge only when `ce_n` is low and reset is inactive. While `ce_n` is high, the position holds.
- R3: An active reset clears both counters on the next rising edge. After release, the stream restarts at bit 0.
- R4: With `RST_HIGH=1`, reset is active while `rst_oe` is 1. With `RST_HIGH=0`, reset is active while `rst_oe` is 0.
- R5: `data_oe` is 1 only when `ce_n` is low, reset is inactive and bits remain. While `data_oe` is 0, `data` reads 0.
- R6: `ceo_n` is 0 exactly when `ce_n` is low, reset is inactive and all `CAP_BITS` bits have been sent. Otherwise it is 1.
- R7: After the last bit, the counters hold and do not wrap. `data_oe` stays 0 until a reset.
- R8: When `ceo_n` drives the next memory's `ce_n`, the next memory's bit 0 appears in the cycle right after the first memory's last bit.
- R9: Capacity is the parameter `CAP_BITS` (default 1048576, a multiple of `WORD_W`). A full readout drives exactly `CAP_BITS` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock from the loading device |
| ce_n | input | 1 | Active-low chip enable |
| rst_oe | input | 1 | Combined reset and output enable; polarity set by `RST_HIGH` |
| data | output | 1 | Current serial bit |
| data_oe | output | 1 | High while `data` is actively driven |
| ceo_n | output | 1 | Active-low cascade enable for the next memory |

## Verification
Two memories are chained, with opposite bit orders and opposite reset polarities, and a behavioural model is compared with them on every cycle. An uninterrupted run shows whether bit ordering and the word pattern are right. A pause with chip enable high shows whether the position is held or skipped. The handover from the first memory to the second shows whether the cascade leaves a gap or repeats a bit. A reset in mid-stream, and idling after the end, show apart a restart, a wrap-around and a stall.

// File: rtl/cfg_srom_pkg.sv
package cfg_srom_pkg;
   // Stored word at a given word address, before truncation to the word width.
   function automatic logic [31:0] pattern_word(input logic [31:0] addr,
                                                input int unsigned mult,
                                                input int unsigned seed);
      return addr * mult + seed;
   endfunction
endpackage

// File: rtl/cfg_srom_ctr.sv
module cfg_srom_ctr #(
   parameter int unsigned WORD_W = 8,
   parameter int unsigned NWORDS = 131072,
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned BIT_W  = 3
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic [BIT_W-1:0]  bitp,
   output logic              done
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NWORDS);
   localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);

   assign done = (addr == LAST_ADDR);

   always_ff @(posedge clk) begin
      if (clr) begin
         addr <= '0;
         bitp <= '0;
      end else if (step && !done) begin
         if (bitp == LAST_BIT) begin
            bitp <= '0;
            addr <= addr + 1'b1;
         end else begin
            bitp <= bitp + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cfg_srom_bitsel.sv
module cfg_srom_bitsel #(
   parameter int unsigned WORD_W    = 8,
   parameter int unsigned ADDR_W    = 18,
   parameter int unsigned BIT_W     = 3,
   parameter bit          MSB_FIRST = 1'b1,
   parameter int unsigned MULT      = 37,
   parameter int unsigned SEED      = 90
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BIT_W-1:0]  bitp,
   output logic              bit_o
);
   localparam logic [BIT_W-1:0] TOP_POS = BIT_W'(WORD_W - 1);

   logic [31:0]       word_full;
   logic [WORD_W-1:0] word;

   assign word_full = cfg_srom_pkg::pattern_word(32'(addr), MULT, SEED);
   assign word      = word_full[WORD_W-1:0];

   generate
      if (MSB_FIRST) begin : g_msb
         assign bit_o = word[TOP_POS - bitp];
      end else begin : g_lsb
         assign bit_o = word[bitp];
      end
   endgenerate
endmodule

// File: rtl/cfg_srom_gate.sv
module cfg_srom_gate #(
   parameter bit RST_HIGH = 1'b1
) (
   input  logic ce_n,
   input  logic rst_oe,
   input  logic done,
   output logic rst_act,
   output logic step,
   output logic oe,
   output logic ceo_n
);
   generate
      if (RST_HIGH) begin : g_rst_hi
         assign rst_act = rst_oe;
      end else begin : g_rst_lo
         assign rst_act = ~rst_oe;
      end
   endgenerate

   assign step  = ~ce_n & ~rst_act;
   assign oe    = step & ~done;
   assign ceo_n = ~(step & done);
endmodule

// File: rtl/cfg_serial_rom.sv
module cfg_serial_rom #(
   parameter int unsigned CAP_BITS  = 1048576,
   parameter int unsigned WORD_W    = 8,
   parameter bit          MSB_FIRST = 1'b1,
   parameter bit          RST_HIGH  = 1'b1,
   parameter int unsigned MULT      = 37,
   parameter int unsigned SEED      = 90
) (
   input  logic clk,
   input  logic ce_n,
   input  logic rst_oe,
   output logic data,
   output logic data_oe,
   output logic ceo_n
);
   localparam int unsigned NWORDS = CAP_BITS / WORD_W;
   localparam int unsigned ADDR_W = $clog2(NWORDS + 1);
   localparam int unsigned BIT_W  = $clog2(WORD_W);

   initial begin
      assert (WORD_W >= 2 && WORD_W <= 32 && (1 << BIT_W) == WORD_W)
         else $error("WORD_W must be a power of two from 2 to 32");
      assert (CAP_BITS >= WORD_W && CAP_BITS % WORD_W == 0)
         else $error("CAP_BITS must be a nonzero multiple of WORD_W");
   end

   logic              rst_act;
   logic              step;
   logic              done;
   logic              oe;
   logic              cur_bit;
   logic [ADDR_W-1:0] addr;
   logic [BIT_W-1:0]  bitp;

   cfg_srom_gate #(.RST_HIGH(RST_HIGH)) u_gate (
      .ce_n(ce_n), .rst_oe(rst_oe), .done(done),
      .rst_act(rst_act), .step(step), .oe(oe), .ceo_n(ceo_n)
   );

   cfg_srom_ctr #(.WORD_W(WORD_W), .NWORDS(NWORDS), .ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_ctr (
      .clk(clk), .clr(rst_act), .step(step),
      .addr(addr), .bitp(bitp), .done(done)
   );

   cfg_srom_bitsel #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .BIT_W(BIT_W),
                     .MSB_FIRST(MSB_FIRST), .MULT(MULT), .SEED(SEED)) u_sel (
      .addr(addr), .bitp(bitp), .bit_o(cur_bit)
   );

   assign data_oe = oe;
   assign data    = oe & cur_bit;
endmodule

// File: rtl/cfg_serial_rom_chk.sv
module cfg_serial_rom_chk #(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned BIT_W  = 3
) (
   input logic              clk,
   input logic              rst_act,
   input logic              ce_n,
   input logic              done,
   input logic [ADDR_W-1:0] addr,
   input logic [BIT_W-1:0]  bitp,
   input logic              data_oe,
   input logic              ceo_n
);
   logic [ADDR_W+BIT_W-1:0] pos;
   assign pos = {addr, bitp};

   p_clear_r3: assert property (@(posedge clk) rst_act |=> (addr == '0 && bitp == '0));
   p_step_r2: assert property (@(posedge clk) disable iff (rst_act)
      (!ce_n && !done) |=> pos == $past(pos) + 1'b1);
   p_hold_r2: assert property (@(posedge clk) disable iff (rst_act)
      ce_n |=> pos == $past(pos));
   p_oe_off_r5: assert property (@(posedge clk) disable iff (rst_act)
      (ce_n || done) |-> !data_oe);
   p_oe_rst_r5: assert property (@(posedge clk) rst_act |-> (!data_oe && ceo_n));
   p_ceo_r6: assert property (@(posedge clk) disable iff (rst_act)
      !ceo_n |-> (done && !ce_n && !data_oe));
   p_nowrap_r7: assert property (@(posedge clk) disable iff (rst_act)
      done |=> done);
endmodule

bind cfg_serial_rom cfg_serial_rom_chk #(.ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_chk (
   .clk(clk), .rst_act(rst_act), .ce_n(ce_n), .done(done),
   .addr(addr), .bitp(bitp), .data_oe(data_oe), .ceo_n(ceo_n)
);

// File: tb/sim_cfg_serial_rom.sv
module sim_cfg_serial_rom;
   localparam int CAP = 64;
   localparam int W   = 8;
   localparam int S0  = 90;
   localparam int S1  = 17;

   logic clk = 1'b0;
   logic ce_n = 1'b0;
   logic rst = 1'b1;
   logic d0, oe0, ceo0, d1, oe1, ceo1;

   int checks = 0;
   int errors = 0;
   int m0 = 0, m1 = 0;
   int oe0_cnt = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   cfg_serial_rom #(.CAP_BITS(CAP), .WORD_W(W), .MSB_FIRST(1'b1), .RST_HIGH(1'b1),
                    .MULT(37), .SEED(S0)) u0 (
      .clk(clk), .ce_n(ce_n), .rst_oe(rst), .data(d0), .data_oe(oe0), .ceo_n(ceo0));

   cfg_serial_rom #(.CAP_BITS(CAP), .WORD_W(W), .MSB_FIRST(1'b0), .RST_HIGH(1'b0),
                    .MULT(37), .SEED(S1)) u1 (
      .clk(clk), .ce_n(ceo0), .rst_oe(~rst), .data(d1), .data_oe(oe1), .ceo_n(ceo1));

   function automatic int bitval(int i, int msb, int seed);
      int a, b, word, p;
      a = i / W;
      b = i % W;
      word = (a * 37 + seed) & ((1 << W) - 1);
      p = msb ? (W - 1 - b) : b;
      return (word >> p) & 1;
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   // Expected outputs from the behavioural model, given current inputs.
   function automatic bit e_oe0();  return !ce_n && !rst && m0 < CAP;           endfunction
   function automatic bit e_ceo0(); return !(!ce_n && !rst && m0 == CAP);       endfunction
   function automatic bit e_oe1();  return !e_ceo0() && !rst && m1 < CAP;       endfunction
   function automatic bit e_ceo1(); return !(!e_ceo0() && !rst && m1 == CAP);   endfunction

   always @(posedge clk) begin
      bit ce1_act;
      ce1_act = !e_ceo0();
      if (rst) begin
         m0 = 0;
         m1 = 0;
      end else begin
         if (!ce_n && m0 < CAP) m0++;
         if (ce1_act && m1 < CAP) m1++;
      end
   end

   always @(negedge clk) begin
      #5;
      if (!finished) begin
         chk("R5 u0 data_oe", oe0, e_oe0());
         chk("R1 u0 data", d0, e_oe0() ? bitval(m0, 1, S0) : 0);
         chk("R6 u0 ceo_n", ceo0, e_ceo0());
         chk("R5 R7 u1 data_oe", oe1, e_oe1());
         chk("R8 u1 data", d1, e_oe1() ? bitval(m1, 0, S1) : 0);
         chk("R6 u1 ceo_n", ceo1, e_ceo1());
         if (rst) oe0_cnt = 0;
         else if (oe0) oe0_cnt++;
      end
   end

   task automatic cycles(int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      cycles(3);
      #5;
      chk("R3 reset state u0 data_oe", oe0, 0);
      chk("R3 reset state u0 ceo_n", ceo0, 1);
      chk("R4 low-active reset holds u1 off", oe1, 0);
      @(negedge clk);
      rst = 1'b0;
      #5;
      chk("R3 first bit after release", d0, bitval(0, 1, S0));
      chk("R4 u1 still disabled by chain", oe1, 0);
      cycles(20);
      ce_n = 1'b1;
      #5;
      chk("R5 ce high disables data", oe0, 0);
      cycles(5);
      ce_n = 1'b0;
      #5;
      chk("R2 position held across pause", d0, bitval(20, 1, S0));
      while (ceo0 !== 1'b0) @(negedge clk);
      #6;
      chk("R9 full readout bit count", oe0_cnt, CAP);
      chk("R8 next memory starts at bit 0", d1, bitval(0, 0, S1));
      chk("R8 next memory enabled", oe1, 1);
      while (ceo1 !== 1'b0) @(negedge clk);
      cycles(10);
      #5;
      chk("R7 no wrap u0", oe0, 0);
      chk("R7 no wrap u1", oe1, 0);
      chk("R6 end of chain ceo_n", ceo1, 0);
      @(negedge clk);
      ce_n = 1'b1;
      #5;
      chk("R6 ceo_n released with ce high", ceo0, 1);
      @(negedge clk);
      ce_n = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #5;
      chk("R3 restart at bit 0", d0, bitval(0, 1, S0));
      cycles(30);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      cycles(3);
      #5;
      chk("R3 mid-stream reset restarts", d0, bitval(3, 1, S0));
      cycles(2);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule